// File: doc/BRIEF.md
# Double-Rate Read Burst Sequencer

This block produces the read-data timing of a memory device with a two-word prefetch. It runs on a clock at twice the command rate. Each pair of internal cycles stands for one external clock period: the cycle with `ck_phase` low is the rising half and the cycle with it high is the falling half. A read request is taken only in a rising half. It carries a bank, a starting column and a burst-length code. After the programmed CAS latency the block streams one data element per internal cycle. Each element is tagged with its bank and column index.

The block also models the data strobe. Before the first element it drives a low preamble for one full external period. During data the strobe is high on even elements and low on odd elements, so the low level on the final element forms the postamble. Once no element and no preamble is due, the strobe goes to high impedance (`dqs_oe` low).

A read whose data window begins right after the last element of a running burst concatenates with it. A read whose window begins earlier cuts the running burst short. In both cases the stream continues with no gap, because the newest read always takes over the data slot it reaches.

Top module: `ddr_rd_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output reads 0 in the following cycle.
- R2: `ck_phase` is 0 in the first cycle after reset and toggles every cycle after that. `rd_req` is accepted only in cycles where `ck_phase` is 0. A request held only in a `ck_phase`=1 cycle produces no data, no preamble and no strobe.
- R3: With `cas_lat_sel`=0 (latency 2) or 1 (latency 3), the first element of an accepted read appears 4 or 6 cycles after the request cycle, with `dq_col` equal to `rd_col` and `dq_bank` equal to `rd_bank`.
- R4: `burst_sel` 0, 1 and 2 give 2, 4 and 8 consecutive elements; code 3 acts as 8. `dq_last` is high only on the final element.
- R5: Element i of a burst of length L carries column (rd_col with its low log2(L) bits replaced by (rd_col + i) mod L), so indices count up and wrap inside an L-aligned block.
- R6: During every element `dqs_oe` is 1 and `dqs_level` is 1 on even element numbers (counting from 0) and 0 on odd ones.
- R7: In the two cycles before a first element that does not follow data directly, `dqs_oe` is 1 and `dqs_level` is 0.
- R8: In any cycle with no element and no preamble due, `dq_valid`, `dq_last`, `dqs_oe` and `dqs_level` are 0.
- R9: A read whose first element falls in the cycle right after the last element of the running burst follows it with no idle cycle.
- R10: A read whose first element falls inside a running burst replaces it from that cycle on, and the remaining elements of the older burst never appear.
- R11: A read that leaves a gap after a burst produces the postamble, then high impedance for any idle cycles outside the preamble window, then a new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, taken when `ck_phase` is 0 |
| rd_bank | input | BANK_W | Bank of the read |
| rd_col | input | COL_W | Starting column of the read |
| burst_sel | input | 2 | Burst length code: 0=2, 1=4, 2 or 3=8 |
| cas_lat_sel | input | CL_W | Latency is CL_MIN + value; change only while idle |
| ck_phase | output | 1 | 0 in rising-half cycles, 1 in falling-half cycles |
| dq_valid | output | 1 | A data element is on the bus this cycle |
| dq_bank | output | BANK_W | Bank of the current element |
| dq_col | output | COL_W | Column index of the current element |
| dq_last | output | 1 | Current element ends its burst |
| dqs_level | output | 1 | Strobe level while driven |
| dqs_oe | output | 1 | Strobe (and data) driven; 0 means high impedance |

## Verification
Two functions collide in one cycle. The first is the launch of a newer read's first element. The second is either the ongoing element stream of an older burst or the preamble window the newer read asks for. The bench provokes this by issuing reads one, two and four command periods apart with burst lengths 4 and 8, at both latencies. A behavioural model marks every cycle from a schedule of per-cycle expectations, where a newer read erases whatever an older one left from its start onward. Each cycle is compared against that schedule, so a dropped, duplicated or late element, a wrong strobe level at the join, or a spurious preamble inside continuous data shows up as a mismatch.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  typedef enum logic [1:0] {
    BSEL_2  = 2'd0,
    BSEL_4  = 2'd1,
    BSEL_8  = 2'd2,
    BSEL_8X = 2'd3
  } bsel_e;

  // index of the final element for a burst-length code
  function automatic logic [2:0] final_index(input logic [1:0] sel);
    case (bsel_e'(sel))
      BSEL_2:  final_index = 3'd1;
      BSEL_4:  final_index = 3'd3;
      default: final_index = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/rd_phase_gen.sv
module rd_phase_gen (
  input  logic clk,
  input  logic rst,
  output logic ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  // R2: half-cycle marker alternates every cycle once running
  assert_phase_toggles_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ph != $past(ph)));
endmodule

// File: rtl/rd_cmd_delay.sv
module rd_cmd_delay #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int CL_MIN = 2,
  parameter int CL_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  logic [1:0]        in_bsel,
  input  logic [CL_W-1:0]   cl_sel,
  output logic              launch_vld,
  output logic [BANK_W-1:0] launch_bank,
  output logic [COL_W-1:0]  launch_col,
  output logic [1:0]        launch_bsel,
  output logic              pre_vld
);
  localparam int CL_MAX = CL_MIN + (1 << CL_W) - 1;
  localparam int DEPTH  = 2 * CL_MAX - 1;
  localparam int IDX_W  = $clog2(DEPTH);

  logic [DEPTH-1:0]  st_vld;
  logic [BANK_W-1:0] st_bank [DEPTH];
  logic [COL_W-1:0]  st_col  [DEPTH];
  logic [1:0]        st_bsel [DEPTH];

  // stage k holds a request k+1 cycles after its request cycle
  always_ff @(posedge clk) begin
    if (rst) st_vld <= '0;
    else     st_vld <= {st_vld[DEPTH-2:0], in_vld};
  end

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          st_bank[0] <= in_bank;
          st_col[0]  <= in_col;
          st_bsel[0] <= in_bsel;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          st_bank[k] <= st_bank[k-1];
          st_col[k]  <= st_col[k-1];
          st_bsel[k] <= st_bsel[k-1];
        end
      end
    end
  endgenerate

  // launch tap: registered output appears 2*CL cycles after the request
  logic [IDX_W-1:0] tap_l, tap_p1, tap_p2;
  assign tap_l  = IDX_W'(2 * (CL_MIN + int'(cl_sel)) - 2);
  assign tap_p1 = tap_l - IDX_W'(1);
  assign tap_p2 = tap_l - IDX_W'(2);

  assign launch_vld  = st_vld[tap_l];
  assign launch_bank = st_bank[tap_l];
  assign launch_col  = st_col[tap_l];
  assign launch_bsel = st_bsel[tap_l];
  assign pre_vld     = st_vld[tap_p1] | st_vld[tap_p2];
endmodule

// File: rtl/rd_burst_engine.sv
module rd_burst_engine #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_vld,
  input  logic [BANK_W-1:0] launch_bank,
  input  logic [COL_W-1:0]  launch_col,
  input  logic [1:0]        launch_bsel,
  output logic              emit_nxt,
  output logic              even_nxt,
  output logic              dq_valid,
  output logic [BANK_W-1:0] dq_bank,
  output logic [COL_W-1:0]  dq_col,
  output logic              dq_last
);
  import ddr_rd_pkg::*;

  logic             busy, busy_n;
  logic [2:0]       idx, idx_n;
  logic [2:0]       lim, lim_n;
  logic [COL_W-1:0] base, base_n;
  logic [COL_W-1:0] col_n, mask, walk;
  logic [BANK_W-1:0] bank_n;
  logic             last_n;

  assign mask = COL_W'(lim);
  assign walk = (base & ~mask) | ((base + COL_W'(idx)) & mask);

  always_comb begin
    emit_nxt = 1'b0;
    even_nxt = 1'b0;
    col_n    = dq_col;
    bank_n   = dq_bank;
    last_n   = 1'b0;
    idx_n    = idx;
    busy_n   = busy;
    lim_n    = lim;
    base_n   = base;
    if (launch_vld) begin
      // newest read takes the slot: truncates or concatenates
      emit_nxt = 1'b1;
      even_nxt = 1'b1;
      col_n    = launch_col;
      bank_n   = launch_bank;
      idx_n    = 3'd1;
      busy_n   = 1'b1;
      lim_n    = final_index(launch_bsel);
      base_n   = launch_col;
    end else if (busy) begin
      emit_nxt = 1'b1;
      even_nxt = ~idx[0];
      col_n    = walk;
      last_n   = (idx == lim);
      idx_n    = idx + 3'd1;
      busy_n   = (idx != lim);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      lim      <= '0;
      base     <= '0;
      dq_valid <= 1'b0;
      dq_bank  <= '0;
      dq_col   <= '0;
      dq_last  <= 1'b0;
    end else begin
      busy     <= busy_n;
      idx      <= idx_n;
      lim      <= lim_n;
      base     <= base_n;
      dq_valid <= emit_nxt;
      dq_bank  <= bank_n;
      dq_col   <= col_n;
      dq_last  <= last_n;
    end
  end

  // R9: an unfinished burst is always followed by another element
  assert_no_gap_inside_R9: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && !dq_last) |=> dq_valid);
endmodule

// File: rtl/rd_strobe_gen.sv
module rd_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic emit_nxt,
  input  logic even_nxt,
  input  logic pre_nxt,
  output logic dqs_level,
  output logic dqs_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_level <= 1'b0;
      dqs_oe    <= 1'b0;
    end else begin
      dqs_oe    <= emit_nxt | pre_nxt;
      dqs_level <= emit_nxt & even_nxt;
    end
  end

  // R7: the strobe always leaves high impedance at a low level
  assert_enable_starts_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_oe) |-> !dqs_level);
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int CL_MIN = 2,
  parameter int CL_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [1:0]        burst_sel,
  input  logic [CL_W-1:0]   cas_lat_sel,
  output logic              ck_phase,
  output logic              dq_valid,
  output logic [BANK_W-1:0] dq_bank,
  output logic [COL_W-1:0]  dq_col,
  output logic              dq_last,
  output logic              dqs_level,
  output logic              dqs_oe
);
  logic              accept;
  logic              l_vld, p_vld, emit_n, even_n;
  logic [BANK_W-1:0] l_bank;
  logic [COL_W-1:0]  l_col;
  logic [1:0]        l_bsel;

  rd_phase_gen u_phase (.clk(clk), .rst(rst), .ph(ck_phase));

  assign accept = rd_req & ~ck_phase;

  rd_cmd_delay #(.BANK_W(BANK_W), .COL_W(COL_W), .CL_MIN(CL_MIN), .CL_W(CL_W)) u_delay (
    .clk(clk), .rst(rst),
    .in_vld(accept), .in_bank(rd_bank), .in_col(rd_col), .in_bsel(burst_sel),
    .cl_sel(cas_lat_sel),
    .launch_vld(l_vld), .launch_bank(l_bank), .launch_col(l_col), .launch_bsel(l_bsel),
    .pre_vld(p_vld)
  );

  rd_burst_engine #(.BANK_W(BANK_W), .COL_W(COL_W)) u_engine (
    .clk(clk), .rst(rst),
    .launch_vld(l_vld), .launch_bank(l_bank), .launch_col(l_col), .launch_bsel(l_bsel),
    .emit_nxt(emit_n), .even_nxt(even_n),
    .dq_valid(dq_valid), .dq_bank(dq_bank), .dq_col(dq_col), .dq_last(dq_last)
  );

  rd_strobe_gen u_strobe (
    .clk(clk), .rst(rst),
    .emit_nxt(emit_n), .even_nxt(even_n), .pre_nxt(p_vld),
    .dqs_level(dqs_level), .dqs_oe(dqs_oe)
  );

  // R6: data is never on the bus without the strobe driven
  assert_data_has_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dqs_oe);

  // R6: elements in rising halves are even, so the strobe is high
  assert_rising_half_high_R6: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && !ck_phase) |-> dqs_level);

  // R7: a stream starting from idle is preceded by a driven low strobe
  assert_preamble_before_data_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> ($past(dqs_oe) && !$past(dqs_level)));
endmodule

// File: tb/ddr_rd_seq_tb.sv
module ddr_rd_seq_tb;
  localparam int BW = 2;
  localparam int CW = 10;
  localparam int NC = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [BW-1:0] rd_bank = '0;
  logic [CW-1:0] rd_col = '0;
  logic [1:0]    burst_sel = '0;
  logic          cas_lat_sel = 1'b0;
  logic          ck_phase, dq_valid, dq_last, dqs_level, dqs_oe;
  logic [BW-1:0] dq_bank;
  logic [CW-1:0] dq_col;

  always #10 clk = ~clk;

  ddr_rd_seq #(.BANK_W(BW), .COL_W(CW), .CL_MIN(2), .CL_W(1)) u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_bank(rd_bank), .rd_col(rd_col),
    .burst_sel(burst_sel), .cas_lat_sel(cas_lat_sel),
    .ck_phase(ck_phase), .dq_valid(dq_valid), .dq_bank(dq_bank), .dq_col(dq_col),
    .dq_last(dq_last), .dqs_level(dqs_level), .dqs_oe(dqs_oe)
  );

  int cyc = 0, r0 = -1, n_cmp = 0, n_bad = 0, cl_now = 2;
  bit done = 0;
  bit ev [NC];
  int ecol [NC], ebank [NC], eidx [NC], etag [NC];
  bit elast [NC];

  function automatic string tagname(int c);
    case (c)
      3: return "R3";
      4: return "R4";
      9: return "R9";
      10: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // model: schedule a request accepted in cycle n
  task automatic sched(int n, int b, int c, int s);
    int bl, st, base;
    bit trunc, seam;
    bl = (s == 0) ? 2 : (s == 1) ? 4 : 8;
    st = n + 2 * cl_now;
    trunc = 0;
    for (int k = st; k < st + 16; k++) if (ev[k]) trunc = 1;
    seam = ev[st-1];
    for (int k = st; k < st + 16; k++) ev[k] = 0;
    base = c & ~(bl - 1);
    for (int i = 0; i < bl; i++) begin
      ev[st+i]    = 1;
      ecol[st+i]  = base | ((c + i) & (bl - 1));
      ebank[st+i] = b;
      eidx[st+i]  = i;
      elast[st+i] = (i == bl - 1);
      etag[st+i]  = (i == 0) ? (trunc ? 10 : (seam ? 9 : 3)) : ((i == bl - 1) ? 4 : 5);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && r0 >= 0 && rd_req && ((cyc - r0) % 2 == 0))
      sched(cyc, int'(rd_bank), int'(rd_col), int'(burst_sel));
    cyc++;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (r0 >= 0 && !done) begin
      bit pre, exp_oe;
      string st;
      int m;
      m = cyc;
      chk("R2", "ck_phase", int'(ck_phase), (m - r0) % 2);
      st = ev[m] ? tagname(etag[m]) : "R2 R8";
      chk(st, "dq_valid", int'(dq_valid), int'(ev[m]));
      if (ev[m]) begin
        chk(st, "dq_col", int'(dq_col), ecol[m]);
        chk(st, "dq_bank", int'(dq_bank), ebank[m]);
        chk("R4", "dq_last", int'(dq_last), int'(elast[m]));
      end else begin
        chk("R8", "dq_last", int'(dq_last), 0);
      end
      pre = !ev[m] && (ev[m+1] || ev[m+2]);
      exp_oe = ev[m] || pre;
      st = ev[m] ? "R6" : (pre ? "R7" : "R8 R11");
      chk(st, "dqs_oe", int'(dqs_oe), int'(exp_oe));
      chk(st, "dqs_level", int'(dqs_level), int'(ev[m] && (eidx[m] % 2 == 0)));
    end
  end

  task automatic issue(int b, int c, int s);
    while (((cyc - r0) % 2) != 0) @(negedge clk);
    rd_req = 1'b1; rd_bank = BW'(b); rd_col = CW'(c); burst_sel = 2'(s);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scenarios();
    // plain bursts of each length, wrap inside aligned blocks
    issue(1, 5, 1);    idle(16);
    issue(2, 13, 2);   idle(20);
    issue(3, 3, 0);    idle(12);
    issue(0, 30, 3);   idle(20);
    // concatenation: x equals pair count
    issue(1, 8, 1);    idle(2);
    issue(2, 21, 1);   idle(16);
    // truncation of a long burst one and two periods later
    issue(0, 40, 2);
    issue(3, 50, 1);   idle(16);
    issue(0, 41, 2);   idle(2);
    issue(1, 63, 2);   idle(24);
    // gaps: one idle period, then a longer one
    issue(2, 6, 0);    idle(2);
    issue(2, 7, 0);    idle(6);
    issue(1, 9, 0);    idle(16);
    // request during a falling half must be ignored (R2)
    while (((cyc - r0) % 2) != 1) @(negedge clk);
    rd_req = 1'b1; rd_col = CW'(99);
    @(negedge clk);
    rd_req = 1'b0;
    idle(16);
  endtask

  initial begin
    idle(3);
    // R1: outputs quiet while reset is held
    chk("R1", "dq_valid", int'(dq_valid), 0);
    chk("R1", "dq_col", int'(dq_col), 0);
    chk("R1", "dq_bank", int'(dq_bank), 0);
    chk("R1", "dq_last", int'(dq_last), 0);
    chk("R1", "dqs_oe", int'(dqs_oe), 0);
    chk("R1", "dqs_level", int'(dqs_level), 0);
    chk("R1", "ck_phase", int'(ck_phase), 0);
    rst = 1'b0;
    r0 = cyc;
    scenarios();
    // latency 3 (R3), changed while idle
    cas_lat_sel = 1'b1;
    cl_now = 3;
    scenarios();
    idle(10);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule